// File: doc/BRIEF.md
# Dual Receive Queue Lock Controller

This block keeps the pointers and lock state for two circular receive queues held in an external buffer memory. The receive side strobes a write into a queue. When that write makes the write pointer catch up with the read pointer, the queue is full. It then locks, refuses further writes and drops its receive-enable. The host reads from either queue by issuing a request with a 3-bit code. A request is acknowledged only when the chosen queue holds data.

A lock can be released in two ways. The first is a command from the node processor. The second is an optional auto-unlock. Auto-unlock releases the lock after a programmable number of host read acknowledges, or as soon as the queue has been drained completely. The auto-unlock enable bit can be changed only while the chip is in its initialization or memory-active operating mode. When dual-queue mode is off, only the first queue is active.

Top module: `rxq_lock_ctrl`

## Requirements
- R1: After reset all pointers are zero and no queue is locked. Each write strobe on an enabled, unlocked queue advances its write pointer. When the advanced write pointer equals the read pointer, the queue locks, sets its `lock_sts` bit, drops its `rx_en` bit and ignores further write strobes until it is unlocked.
- R2: A command (`cmd_vld` high) with code 8'h20 unlocks queue 1, 8'h21 unlocks queue 2, and 8'h3F unlocks both. Any other code has no effect. A lock set by a filling write in the same cycle wins over the command.
- R3: With `dual_en` low, queue 2 is disabled: its writes are ignored, its read requests are never acknowledged, and `data_avail[1]` and `rx_en[1]` are held low.
- R4: A read request uses code 3'b000 for queue 1 and 3'b001 for queue 2. It produces a one-cycle pulse on bit 0 or bit 1 of `rd_ack` one clock after the request, only if that queue's `data_avail` was high in the request cycle. Every other code is never acknowledged, and at most one ack bit is high.
- R5: `data_avail[i]` is high while queue i holds unread entries, which includes a full queue. It falls once the last entry has been acknowledged.
- R6: The auto-unlock enable bit is 0 after reset. While it is 0, a locked queue stays locked through any number of reads and is released only by a command.
- R7: A write to the auto-unlock enable bit (`aul_wr`) takes effect only when `op_mode` is 2'b00 (initialization) or 2'b01 (memory active). In the other modes the write is ignored. The one bit governs both queues.
- R8: With auto-unlock on, locking loads the queue's countdown with four times its 8-bit threshold (`thr_q1` or `thr_q2`). Each acknowledge for that queue decrements the countdown. The acknowledge that arrives when the countdown is already zero unlocks the queue, so the lock clears on acknowledge number 4*threshold+1.
- R9: With auto-unlock on, a locked queue also unlocks on the acknowledge that empties it, even if the countdown has not expired.
- R10: A command unlock returns the countdown to idle, so the next lock starts a fresh count of four times the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_en | input | 1 | Enables queue 2 |
| op_mode | input | 2 | Operating mode: 00 init, 01 memory active, 10/11 other |
| aul_wr | input | 1 | Write strobe for the auto-unlock enable bit |
| aul_wdata | input | 1 | Value written to the auto-unlock enable bit |
| thr_q1 | input | 8 | Auto-unlock threshold for queue 1 |
| thr_q2 | input | 8 | Auto-unlock threshold for queue 2 |
| wr_stb | input | 2 | Receive write strobe per queue |
| rd_vld | input | 1 | Host read request valid |
| rd_code | input | 3 | Host request code |
| cmd_vld | input | 1 | Node-processor command valid |
| cmd_code | input | 8 | Command code |
| rd_ack | output | 2 | Read acknowledge per queue, one-cycle pulse |
| data_avail | output | 2 | Queue holds unread data |
| lock_sts | output | 2 | Queue is locked |
| rx_en | output | 2 | Queue accepts receive writes |

## Verification
A read acknowledge is registered, so it appears in the clock cycle after the one in which the request was presented. The scoreboard pushes the expected ack mask when it drives a request and pops it one edge later, 1 ns after that edge. Lock, data-present and receive-enable outputs follow from registered state, so they are due at the edge that captures the triggering write, read or command. The bench drives on falling edges and reads these outputs at the next falling edge. Countdown boundaries are checked on both sides: still locked after acknowledge 4*threshold, released on the acknowledge that follows, and released on the acknowledge that drains a queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int NQ = 2;

    localparam logic [7:0] CMD_CLR_Q1  = 8'h20;
    localparam logic [7:0] CMD_CLR_Q2  = 8'h21;
    localparam logic [7:0] CMD_CLR_ALL = 8'h3F;

    localparam logic [2:0] REQ_Q1 = 3'b000;
    localparam logic [2:0] REQ_Q2 = 3'b001;

    typedef enum logic [1:0] {
        OPM_INIT   = 2'b00,
        OPM_MEMACT = 2'b01,
        OPM_ONLINE = 2'b10,
        OPM_OTHER  = 2'b11
    } opmode_e;
endpackage

// File: rtl/rxq_cmd_dec.sv
module rxq_cmd_dec
    import rxq_pkg::*;
(
    input  logic          cmd_vld,
    input  logic [7:0]    cmd_code,
    output logic [NQ-1:0] clr
);
    always_comb begin
        clr = '0;
        if (cmd_vld) begin
            unique case (cmd_code)
                CMD_CLR_Q1:  clr = 2'b01;
                CMD_CLR_Q2:  clr = 2'b10;
                CMD_CLR_ALL: clr = 2'b11;
                default:     clr = '0;
            endcase
        end
    end
endmodule

// File: rtl/rxq_req_dec.sv
module rxq_req_dec
    import rxq_pkg::*;
(
    input  logic          rd_vld,
    input  logic [2:0]    rd_code,
    input  logic          dual_en,
    output logic [NQ-1:0] sel
);
    always_comb begin
        sel = '0;
        if (rd_vld) begin
            if (rd_code == REQ_Q1)
                sel[0] = 1'b1;
            else if (rd_code == REQ_Q2 && dual_en)
                sel[1] = 1'b1;
        end
    end
endmodule

// File: rtl/rxq_mode_reg.sv
module rxq_mode_reg
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_mode,
    input  logic       aul_wr,
    input  logic       aul_wdata,
    output logic       aul_en
);
    typedef struct packed {
        logic aul;
    } mode_t;

    mode_t mode_d, mode_q;
    logic  wr_ok;

    always_comb begin
        mode_d = mode_q;
        wr_ok  = (opmode_e'(op_mode) == OPM_INIT) || (opmode_e'(op_mode) == OPM_MEMACT);
        if (aul_wr && wr_ok)
            mode_d.aul = aul_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else
            mode_q <= mode_d;
    end

    assign aul_en = mode_q.aul;
endmodule

// File: rtl/rxq_queue_ctrl.sv
module rxq_queue_ctrl #(
    parameter int PTR_W = 10,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_stb,
    input  logic             rd_sel,
    input  logic             clr_cmd,
    input  logic             aul_en,
    input  logic [THR_W-1:0] thr,
    output logic             rd_ack,
    output logic             data_avail,
    output logic             locked,
    output logic             rx_en
);
    localparam int CNT_W = THR_W + 2;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic             full;
        logic             lock;
        logic [CNT_W-1:0] cnt;
        logic             ack;
    } qstate_t;

    qstate_t st_d, st_q;

    logic             avail;
    logic             do_rd;
    logic             do_wr;
    logic [PTR_W-1:0] rp_nxt;
    logic [PTR_W-1:0] wp_nxt;
    logic             drained;

    always_comb begin
        st_d    = st_q;
        avail   = st_q.full || (st_q.wp != st_q.rp);
        do_rd   = en && rd_sel && avail;
        do_wr   = en && wr_stb && !st_q.lock;
        rp_nxt  = st_q.rp + {{(PTR_W-1){1'b0}}, do_rd};
        wp_nxt  = st_q.wp + {{(PTR_W-1){1'b0}}, do_wr};
        drained = do_rd && (rp_nxt == st_q.wp) && !do_wr;

        st_d.rp  = rp_nxt;
        st_d.wp  = wp_nxt;
        st_d.ack = do_rd;

        if (do_rd)
            st_d.full = 1'b0;

        if (clr_cmd) begin
            st_d.lock = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.lock && aul_en && do_rd) begin
            if (st_q.cnt == '0 || drained) begin
                st_d.lock = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (do_wr && (wp_nxt == rp_nxt)) begin
            st_d.full = 1'b1;
            st_d.lock = 1'b1;
            st_d.cnt  = {thr, 2'b00};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_ack     = st_q.ack;
    assign data_avail = en && (st_q.full || (st_q.wp != st_q.rp));
    assign locked     = st_q.lock;
    assign rx_en      = en && !st_q.lock;
endmodule

// File: rtl/rxq_lock_ctrl.sv
module rxq_lock_ctrl
    import rxq_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dual_en,
    input  logic [1:0]       op_mode,
    input  logic             aul_wr,
    input  logic             aul_wdata,
    input  logic [THR_W-1:0] thr_q1,
    input  logic [THR_W-1:0] thr_q2,
    input  logic [1:0]       wr_stb,
    input  logic             rd_vld,
    input  logic [2:0]       rd_code,
    input  logic             cmd_vld,
    input  logic [7:0]       cmd_code,
    output logic [1:0]       rd_ack,
    output logic [1:0]       data_avail,
    output logic [1:0]       lock_sts,
    output logic [1:0]       rx_en
);
    logic [NQ-1:0]    clr_vec;
    logic [NQ-1:0]    sel_vec;
    logic [NQ-1:0]    q_en;
    logic [THR_W-1:0] thr_arr [NQ];
    logic             aul_en_q;

    assign q_en       = {dual_en, 1'b1};
    assign thr_arr[0] = thr_q1;
    assign thr_arr[1] = thr_q2;

    rxq_cmd_dec u_cmd (
        .cmd_vld  (cmd_vld),
        .cmd_code (cmd_code),
        .clr      (clr_vec)
    );

    rxq_req_dec u_req (
        .rd_vld  (rd_vld),
        .rd_code (rd_code),
        .dual_en (dual_en),
        .sel     (sel_vec)
    );

    rxq_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_mode   (op_mode),
        .aul_wr    (aul_wr),
        .aul_wdata (aul_wdata),
        .aul_en    (aul_en_q)
    );

    for (genvar gi = 0; gi < NQ; gi++) begin : g_q
        rxq_queue_ctrl #(
            .PTR_W (PTR_W),
            .THR_W (THR_W)
        ) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (q_en[gi]),
            .wr_stb     (wr_stb[gi]),
            .rd_sel     (sel_vec[gi]),
            .clr_cmd    (clr_vec[gi]),
            .aul_en     (aul_en_q),
            .thr        (thr_arr[gi]),
            .rd_ack     (rd_ack[gi]),
            .data_avail (data_avail[gi]),
            .locked     (lock_sts[gi]),
            .rx_en      (rx_en[gi])
        );
    end
endmodule

// File: rtl/rxq_lock_sva.sv
module rxq_lock_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       dual_en,
    input logic       aul_en,
    input logic       cmd_vld,
    input logic [7:0] cmd_code,
    input logic [1:0] wr_stb,
    input logic [1:0] rd_ack,
    input logic [1:0] data_avail,
    input logic [1:0] lock_sts
);
    AST_ACK_NEEDS_DATA_Q1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack[0] |-> $past(data_avail[0])); // R4

    AST_ACK_NEEDS_DATA_Q2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack[1] |-> $past(data_avail[1])); // R4

    AST_ACK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_ack)); // R4

    AST_CLR_ALL_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_code == 8'h3F && wr_stb == 2'b00) |=> (lock_sts == 2'b00)); // R2

    AST_MANUAL_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_sts[0] && !aul_en && !(cmd_vld && (cmd_code == 8'h20 || cmd_code == 8'h3F)))
        |=> lock_sts[0]); // R6

    AST_Q2_OFF_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_en |=> !rd_ack[1]); // R3
endmodule

bind rxq_lock_ctrl rxq_lock_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .dual_en    (dual_en),
    .aul_en     (aul_en_q),
    .cmd_vld    (cmd_vld),
    .cmd_code   (cmd_code),
    .wr_stb     (wr_stb),
    .rd_ack     (rd_ack),
    .data_avail (data_avail),
    .lock_sts   (lock_sts)
);

// File: tb/sim_rxq_lock_ctrl.sv
`timescale 1ns/1ps
module sim_rxq_lock_ctrl;
    localparam int PTR_W = 4;
    localparam int DEPTH = 1 << PTR_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dual_en = 1'b1;
    logic [1:0] op_mode = 2'b00;
    logic       aul_wr = 1'b0;
    logic       aul_wdata = 1'b0;
    logic [7:0] thr_q1 = 8'd0;
    logic [7:0] thr_q2 = 8'd0;
    logic [1:0] wr_stb = 2'b00;
    logic       rd_vld = 1'b0;
    logic [2:0] rd_code = 3'b000;
    logic       cmd_vld = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic [1:0] rd_ack;
    logic [1:0] data_avail;
    logic [1:0] lock_sts;
    logic [1:0] rx_en;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    logic [1:0] exp_ack_q[$];
    string      exp_tag_q[$];

    always #2.5 clk = ~clk;

    rxq_lock_ctrl #(.PTR_W(PTR_W), .THR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .op_mode(op_mode),
        .aul_wr(aul_wr), .aul_wdata(aul_wdata), .thr_q1(thr_q1), .thr_q2(thr_q2),
        .wr_stb(wr_stb), .rd_vld(rd_vld), .rd_code(rd_code),
        .cmd_vld(cmd_vld), .cmd_code(cmd_code), .rd_ack(rd_ack),
        .data_avail(data_avail), .lock_sts(lock_sts), .rx_en(rx_en)
    );

    // monitor: pops one expected ack mask per edge (empty queue means no ack due)
    always @(posedge clk) begin
        #1;
        cyc++;
        if (mon_on) begin
            logic [1:0] e;
            string      t;
            e = 2'b00;
            t = "R4 idle";
            if (exp_ack_q.size() > 0) begin
                e = exp_ack_q.pop_front();
                t = exp_tag_q.pop_front();
            end
            n_chk++;
            if (rd_ack !== e) begin
                n_fail++;
                $display("FAIL %s rd_ack act=%b exp=%b", t, rd_ack, e);
            end
        end
    end

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] code, input logic [1:0] exp, input string tag);
        @(negedge clk);
        rd_vld  = 1'b1;
        rd_code = code;
        exp_ack_q.push_back(exp);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        rd_vld = 1'b0;
    endtask

    task automatic rd_n(input logic [2:0] code, input int n, input logic [1:0] exp, input string tag);
        for (int i = 0; i < n; i++) rd(code, exp, tag);
    endtask

    task automatic wr(input logic [1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_stb = m;
            @(negedge clk);
            wr_stb = 2'b00;
        end
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_vld  = 1'b1;
        cmd_code = c;
        @(negedge clk);
        cmd_vld = 1'b0;
    endtask

    task automatic set_aul(input logic [1:0] mode, input logic v);
        @(negedge clk);
        op_mode   = mode;
        aul_wr    = 1'b1;
        aul_wdata = v;
        @(negedge clk);
        aul_wr = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R1 reset state
        chk("R1 reset lock_sts", lock_sts, 2'b00);
        chk("R1 reset rx_en", rx_en, 2'b11);
        chk("R5 reset data_avail", data_avail, 2'b00);

        // R5/R4 basic traffic on queue 1
        wr(2'b01, 3);
        chk("R5 q1 data present", data_avail, 2'b01);
        rd_n(3'b000, 3, 2'b01, "R4 q1 read");
        chk("R5 q1 drained", data_avail, 2'b00);
        rd(3'b000, 2'b00, "R4 q1 empty no ack");
        rd(3'b001, 2'b00, "R4 q2 empty no ack");
        wr(2'b10, 1);
        rd(3'b010, 2'b00, "R4 bad code no ack");
        rd(3'b001, 2'b10, "R4 q2 read");

        // R1 fill and lock queue 1, R6 manual-only release
        wr(2'b01, DEPTH);
        chk("R1 q1 locked", lock_sts, 2'b01);
        chk("R1 q1 rx_en low", rx_en, 2'b10);
        wr(2'b01, 1);
        rd_n(3'b000, DEPTH, 2'b01, "R6 q1 read while locked");
        chk("R6 q1 still locked", lock_sts, 2'b01);
        rd(3'b000, 2'b00, "R1 extra write dropped");
        // R2 commands
        cmd(8'h55);
        chk("R2 unknown code ignored", lock_sts, 2'b01);
        cmd(8'h21);
        chk("R2 21h leaves q1", lock_sts, 2'b01);
        cmd(8'h20);
        chk("R2 20h unlocks q1", lock_sts, 2'b00);
        chk("R2 q1 rx_en back", rx_en, 2'b11);

        // R7 enable write ignored outside init/memory-active
        thr_q2 = 8'd2;
        set_aul(2'b10, 1'b1);
        wr(2'b10, DEPTH);
        chk("R1 q2 locked", lock_sts, 2'b10);
        rd_n(3'b001, 9, 2'b10, "R7 q2 read");
        chk("R7 ignored write keeps manual lock", lock_sts, 2'b10);
        cmd(8'h3F);
        chk("R2 3Fh unlocks all", lock_sts, 2'b00);
        rd_n(3'b001, DEPTH - 9, 2'b10, "R7 q2 drain");
        rd(3'b001, 2'b00, "R5 q2 empty");

        // R8 countdown: threshold 2 -> lock held for 8 acks, released on the 9th
        set_aul(2'b00, 1'b1);
        wr(2'b10, DEPTH);
        chk("R8 q2 locked", lock_sts, 2'b10);
        rd_n(3'b001, 8, 2'b10, "R8 q2 read");
        chk("R8 still locked after 8", lock_sts, 2'b00 | 2'b10);
        rd(3'b001, 2'b10, "R8 q2 ninth read");
        chk("R8 unlocked after 9", lock_sts, 2'b00);
        rd_n(3'b001, DEPTH - 9, 2'b10, "R8 q2 drain");

        // R9 drain unlock: threshold 5 -> 20 > depth 16
        thr_q1 = 8'd5;
        wr(2'b01, DEPTH);
        chk("R9 q1 locked", lock_sts, 2'b01);
        rd_n(3'b000, DEPTH - 1, 2'b01, "R9 q1 read");
        chk("R9 locked before last", lock_sts, 2'b01);
        rd(3'b000, 2'b01, "R9 q1 last read");
        chk("R9 unlocked on empty", lock_sts, 2'b00);
        chk("R9 q1 empty", data_avail, 2'b00);

        // R10 command resets the count, next lock restarts at 4*thr
        wr(2'b10, DEPTH);
        rd_n(3'b001, 3, 2'b10, "R10 q2 read");
        cmd(8'h21);
        chk("R10 cmd unlock", lock_sts, 2'b00);
        wr(2'b10, 3);
        chk("R10 relocked", lock_sts, 2'b10);
        rd_n(3'b001, 8, 2'b10, "R10 q2 read");
        chk("R10 fresh count holds", lock_sts, 2'b10);
        rd(3'b001, 2'b10, "R10 ninth read");
        chk("R10 fresh count releases", lock_sts, 2'b00);

        // R3 single-queue mode: queue 2 has 7 entries left
        @(negedge clk);
        dual_en = 1'b0;
        @(negedge clk);
        chk("R3 q2 data_avail masked", data_avail, 2'b00);
        chk("R3 q2 rx_en low", rx_en, 2'b01);
        rd(3'b001, 2'b00, "R3 q2 read ignored");
        wr(2'b10, 1);
        @(negedge clk);
        dual_en = 1'b1;
        @(negedge clk);
        rd_n(3'b001, DEPTH - 9, 2'b10, "R3 q2 remaining");
        rd(3'b001, 2'b00, "R3 q2 write was dropped");

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 20000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule